// File: doc/BRIEF.md
# 16-bit Timer with Capture and Reload

A 16-bit timer/counter for a microcontroller-style peripheral set. One byte-wide control register holds the run bit, the source select, the capture-or-reload select, the trigger enable, the two baud-clock selects, and two sticky flags. A one-bit mode register adds a count-direction feature. The counter advances either on each count tick (`tickEn`) or on falling edges of an external count pin. A falling edge on the trigger pin can snapshot the counter into a 16-bit capture register, or it can reload the counter from that register.

Which flags the block sets depends on the mode. When either baud-clock select is on, the timer runs at half the tick rate, reloads itself from the capture register, and emits a one-cycle `baudTick` on every wrap for a serial port to use. In this mode the overflow flag is never set. When direction control is on, the `dirPin` input chooses the counting direction. A down count underflows when the counter equals the capture register. The external flag then works as a 17th count bit, and the interrupt request ignores it.

Register map (byte addresses): 0 = control, 1 = mode, 2 = counter low byte, 3 = counter high byte, 4 = capture low byte, 5 = capture high byte. Other addresses read as 0.

Top module: `tmr16_top`

## Requirements
- R1: After reset, every register reads 0 at its address (control 0, mode 1, counter 2/3, capture 4/5), and `ovfFlag`, `extFlag`, `irq` and `baudTick` are all low.
- R2: With the run bit (control bit 2) set, the counter goes up by one on each `tickEn` cycle when the source select (control bit 1) is 0. When the source select is 1, it goes up by one on each falling edge of `cntPin`; an edge counts when `cntPin` is high at one tick and low at the next. With the run bit clear, the counter holds its value.
- R3: The overflow flag (control bit 7, `ovfFlag`) sets when the up count wraps from FFFFh. It stays set through later counting, and only a register write clears it.
- R4: On an up-count wrap with capture/reload select (control bit 0) at 0, the counter loads from the capture register. With the select at 1, the counter wraps to 0000h and the capture register is left unchanged.
- R5: With the trigger enable (control bit 3) set, a falling edge on `trigPin` sets the external flag (control bit 6, `extFlag`). In capture mode it also copies the counter value held before that tick into the capture register. In reload mode it also loads the counter from the capture register, and this load takes priority over the increment in the same tick.
- R6: With the trigger enable clear, a falling edge on `trigPin` changes neither the external flag nor the counter nor the capture register.
- R7: When either baud select (control bit 5 or bit 4) is set, the counter advances on every second qualifying tick. On a wrap it reloads from the capture register and pulses `baudTick` for one cycle. The overflow flag never sets in this mode.
- R8: With direction control (mode bit 0) set and no baud select, `dirPin` = 1 counts up and `dirPin` = 0 counts down. A down tick that finds the counter equal to the capture register loads FFFFh and sets the overflow flag. An up wrap from FFFFh loads the counter from the capture register and sets the overflow flag.
- R9: In direction-control mode, the external flag toggles on every wrap in either direction and is left out of `irq`.
- R10: Outside direction-control mode, `irq` is the OR of the overflow and external flags. Writing 1 to the external flag bit raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count tick enable; also the rate at which the pins are sampled |
| cntPin | input | 1 | External count input |
| trigPin | input | 1 | External capture/reload trigger |
| dirPin | input | 1 | Count direction in direction-control mode (1 = up) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External flag |
| irq | output | 1 | Interrupt request |
| baudTick | output | 1 | One-cycle pulse on each wrap in baud mode |

## Verification
The bench drives the counter up to FFFFh and checks both wrap outcomes. A design with the capture/reload select inverted would reload in capture mode and wrap to zero in reload mode. In baud mode it counts ticks to confirm that only every second one advances the counter and that the overflow flag stays clear; a design without the divider or without the flag suppression fails here. The direction-control test underflows at the capture value, then clears only the overflow flag. A design that still routes the external flag to `irq` would assert the interrupt at that point. The trigger tests pin down which counter value is captured, and that a disabled trigger changes no register.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam int ADDR_CNT0 = 2;

  localparam int BIT_OVF  = 7;
  localparam int BIT_EXT  = 6;
  localparam int BIT_RXB  = 5;
  localparam int BIT_TXB  = 4;
  localparam int BIT_EXEN = 3;
  localparam int BIT_RUN  = 2;
  localparam int BIT_CSEL = 1;
  localparam int BIT_CAP  = 0;

  typedef struct packed {
    logic inc;
    logic dec;
    logic reload;
    logic setMax;
    logic capture;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmrStrobe_t           strobe,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cap,
  output logic                 cntMax,
  output logic                 cntEqCap
);
  localparam int NB = CNT_W / 8;
  localparam int ADDR_CAP0 = ADDR_CNT0 + NB;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [NB-1:0] cntByteWr, capByteWr;
  logic [CNT_W-1:0] cntNext, capNext;
  logic cntWr, capWr;

  for (genvar b = 0; b < NB; b++) begin : g_byteWr
    assign cntByteWr[b] = wrEn && (wrAddr == ADDR_W'(ADDR_CNT0 + b));
    assign capByteWr[b] = wrEn && (wrAddr == ADDR_W'(ADDR_CAP0 + b));
  end

  assign cntWr = |cntByteWr;
  assign capWr = |capByteWr;

  always_comb begin
    cntNext = cnt;
    if (strobe.reload)      cntNext = cap;
    else if (strobe.setMax) cntNext = MAXV;
    else if (strobe.inc)    cntNext = cnt + 1'b1;
    else if (strobe.dec)    cntNext = cnt - 1'b1;
    for (int b = 0; b < NB; b++)
      if (cntByteWr[b]) cntNext[b*8 +: 8] = wrData;
  end

  always_comb begin
    capNext = cap;
    if (strobe.capture) capNext = cnt;
    for (int b = 0; b < NB; b++)
      if (capByteWr[b]) capNext[b*8 +: 8] = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      cap <= '0;
    end else begin
      cnt <= cntNext;
      cap <= capNext;
    end
  end

  assign cntMax   = (cnt == MAXV);
  assign cntEqCap = (cnt == cap);

  // R4: a reload strobe moves the capture value into the counter
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !cntWr && !capWr) |=> (cnt == $past(cap)));

  // R8: an underflow leaves the counter at all ones
  p_underflow_max_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMax && !strobe.reload && !cntWr) |=> (cnt == MAXV));

  // R5: a capture strobe records the counter value held before the tick
  p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !capWr) |=> (cap == $past(cnt)));
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              dirPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              cntMax,
  input  logic              cntEqCap,
  output tmrStrobe_t        strobe,
  output logic [7:0]        ctrlReg,
  output logic              udEn,
  output logic              irq,
  output logic              baudTick
);
  logic cntPrev, trigPrev, preHalf;
  logic baudMode, effUd, cntFall, trigFall, rawTick, countTick, goUp;
  logic ovfEv, unfEv, trigEv, pinAct, reloadOnOvf, ctrlWr;
  logic [7:0] ctrlNext;

  assign baudMode    = ctrlReg[BIT_RXB] | ctrlReg[BIT_TXB];
  assign effUd       = udEn & ~baudMode;
  assign cntFall     = tickEn & cntPrev & ~cntPin;
  assign trigFall    = tickEn & trigPrev & ~trigPin;
  assign rawTick     = ctrlReg[BIT_RUN] & (ctrlReg[BIT_CSEL] ? cntFall : tickEn);
  assign countTick   = rawTick & (~baudMode | preHalf);
  assign goUp        = ~effUd | dirPin;
  assign ovfEv       = countTick & goUp & cntMax;
  assign unfEv       = countTick & ~goUp & cntEqCap;
  assign trigEv      = trigFall & ctrlReg[BIT_EXEN];
  assign pinAct      = ~baudMode & ~effUd;
  assign reloadOnOvf = baudMode | effUd | ~ctrlReg[BIT_CAP];
  assign ctrlWr      = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    strobe.reload  = (ovfEv & reloadOnOvf) | (trigEv & pinAct & ~ctrlReg[BIT_CAP]);
    strobe.setMax  = unfEv;
    strobe.inc     = countTick & goUp & ~(ovfEv & reloadOnOvf);
    strobe.dec     = countTick & ~goUp & ~unfEv;
    strobe.capture = trigEv & pinAct & ctrlReg[BIT_CAP];
  end

  always_comb begin
    ctrlNext = ctrlWr ? wrData : ctrlReg;
    ctrlNext[BIT_OVF] = ctrlNext[BIT_OVF] | ((ovfEv | unfEv) & ~baudMode);
    ctrlNext[BIT_EXT] = (ctrlNext[BIT_EXT] | (trigEv & ~effUd))
                        ^ (effUd & (ovfEv | unfEv));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      udEn     <= 1'b0;
      cntPrev  <= 1'b0;
      trigPrev <= 1'b0;
      preHalf  <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      ctrlReg  <= ctrlNext;
      if (wrEn && (wrAddr == ADDR_MODE)) udEn <= wrData[0];
      if (tickEn) begin
        cntPrev  <= cntPin;
        trigPrev <= trigPin;
      end
      if (rawTick && baudMode) preHalf <= ~preHalf;
      baudTick <= ovfEv & baudMode;
    end
  end

  assign irq = ctrlReg[BIT_OVF] | (ctrlReg[BIT_EXT] & ~effUd);

  // R7: no overflow flag is raised while a baud select is on
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (baudMode && !ctrlWr && !ctrlReg[BIT_OVF]) |=> !ctrlReg[BIT_OVF]);

  // R7: the baud pulse never lasts two cycles
  p_baud_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  // R3: the overflow flag is sticky until a register write
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[BIT_OVF] && !ctrlWr) |=> ctrlReg[BIT_OVF]);

  // R6: with the trigger disabled the external flag cannot rise outside direction mode
  p_ext_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[BIT_EXEN] && !udEn && !ctrlWr && !ctrlReg[BIT_EXT]) |=> !ctrlReg[BIT_EXT]);
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        cntPin,
  input  logic        trigPin,
  input  logic        dirPin,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  output logic        ovfFlag,
  output logic        extFlag,
  output logic        irq,
  output logic        baudTick
);
  localparam int CNT_W = 16;
  localparam int NB = CNT_W / 8;
  localparam int ADDR_CAP0 = ADDR_CNT0 + NB;

  tmrStrobe_t strobe;
  logic [7:0] ctrlReg;
  logic udEn, cntMax, cntEqCap;
  logic [CNT_W-1:0] cnt, cap;

  tmr16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin), .trigPin(trigPin),
    .dirPin(dirPin), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntMax(cntMax), .cntEqCap(cntEqCap), .strobe(strobe), .ctrlReg(ctrlReg),
    .udEn(udEn), .irq(irq), .baudTick(baudTick)
  );

  tmr16_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cnt(cnt), .cap(cap), .cntMax(cntMax), .cntEqCap(cntEqCap)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_CTRL) rdData = ctrlReg;
    if (rdAddr == ADDR_MODE) rdData = {7'd0, udEn};
    for (int b = 0; b < NB; b++) begin
      if (rdAddr == ADDR_W'(ADDR_CNT0 + b)) rdData = cnt[b*8 +: 8];
      if (rdAddr == ADDR_W'(ADDR_CAP0 + b)) rdData = cap[b*8 +: 8];
    end
  end

  assign ovfFlag = ctrlReg[BIT_OVF];
  assign extFlag = ctrlReg[BIT_EXT];
endmodule

// File: tb/tmr16_top_bench.sv
module tmr16_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, cntPin = 1'b1, trigPin = 1'b1, dirPin = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic ovfFlag, extFlag, irq, baudTick;

  int nRun = 0, nFail = 0, baudCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmr16_top u_tmr16_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin), .trigPin(trigPin),
    .dirPin(dirPin), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .ovfFlag(ovfFlag), .extFlag(extFlag), .irq(irq), .baudTick(baudTick)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    logic [7:0] lo;
    @(negedge clk); rdAddr = a; #1 lo = rdData;
    rdAddr = a + 3'd1; #1 v = {rdData, lo};
  endtask

  task automatic rd8(input logic [2:0] a, output int v);
    @(negedge clk); rdAddr = a; #1 v = rdData;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(posedge clk); #2 if (baudTick) baudCnt++;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic testReset();
    int v;
    rd8(3'd0, v); chk("R1 ctrl", v, 0);
    rd8(3'd1, v); chk("R1 mode", v, 0);
    rd16(3'd2, v); chk("R1 counter", v, 0);
    rd16(3'd4, v); chk("R1 capture", v, 0);
    chk("R1 outputs", {ovfFlag, extFlag, irq, baudTick}, 0);
  endtask

  task automatic testUpReload();
    int v;
    wr16(3'd2, 16'hFFFD); wr16(3'd4, 16'h1234); wr(3'd0, 8'h04);
    step(2); rd16(3'd2, v); chk("R2 timer count", v, 16'hFFFF);
    chk("R3 no flag before wrap", ovfFlag, 0);
    step(1); rd16(3'd2, v); chk("R4 reload on wrap", v, 16'h1234);
    chk("R3 flag on wrap", ovfFlag, 1);
    chk("R10 irq from ovf", irq, 1);
    step(1); chk("R3 flag sticky", ovfFlag, 1);
    wr(3'd0, 8'h04); chk("R3 software clear", ovfFlag, 0);
    chk("R10 irq drops", irq, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic testCapture();
    int v;
    wr16(3'd2, 16'h0100); wr(3'd0, 8'h0D);
    trigPin = 1'b1; step(1);
    trigPin = 1'b0; step(1); trigPin = 1'b1;
    rd16(3'd4, v); chk("R5 captured value", v, 16'h0101);
    rd16(3'd2, v); chk("R5 counter after capture", v, 16'h0102);
    chk("R5 ext flag set", extFlag, 1);
    chk("R10 irq from ext", irq, 1);
  endtask

  task automatic testTrigDisabled();
    int v;
    wr(3'd0, 8'h05);
    step(1); trigPin = 1'b0; step(1); trigPin = 1'b1;
    chk("R6 ext flag unchanged", extFlag, 0);
    rd16(3'd4, v); chk("R6 capture unchanged", v, 16'h0101);
    rd16(3'd2, v); chk("R6 counter plain count", v, 16'h0104);
  endtask

  task automatic testTrigReload();
    int v;
    wr(3'd0, 8'h00); wr16(3'd4, 16'h5000); wr16(3'd2, 16'h0010); wr(3'd0, 8'h0C);
    step(1); trigPin = 1'b0; step(1); trigPin = 1'b1;
    rd16(3'd2, v); chk("R5 trigger reload", v, 16'h5000);
    chk("R5 ext flag reload", extFlag, 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic testCaptureWrap();
    int v;
    wr16(3'd2, 16'hFFFF); wr16(3'd4, 16'h1111); wr(3'd0, 8'h05);
    step(1); rd16(3'd2, v); chk("R4 capture mode wraps to zero", v, 0);
    rd16(3'd4, v); chk("R4 capture kept", v, 16'h1111);
    chk("R3 flag on wrap capture mode", ovfFlag, 1);
    wr(3'd0, 8'h00); step(3);
    rd16(3'd2, v); chk("R2 run clear holds", v, 0);
  endtask

  task automatic testCounterPin();
    int v;
    wr16(3'd2, 16'h0000); wr(3'd0, 8'h06);
    cntPin = 1'b1; step(1); cntPin = 1'b0; step(2);
    cntPin = 1'b1; step(1); cntPin = 1'b0; step(1);
    rd16(3'd2, v); chk("R2 pin edges counted", v, 2);
    cntPin = 1'b1; wr(3'd0, 8'h00);
  endtask

  task automatic testBaud();
    int v;
    baudCnt = 0;
    wr16(3'd4, 16'hFFFE); wr16(3'd2, 16'hFFFE); wr(3'd0, 8'h24);
    step(1); rd16(3'd2, v); chk("R7 half rate first tick", v, 16'hFFFE);
    step(1); rd16(3'd2, v); chk("R7 half rate second tick", v, 16'hFFFF);
    step(2); rd16(3'd2, v); chk("R7 baud reload", v, 16'hFFFE);
    chk("R7 one baud pulse", baudCnt, 1);
    chk("R7 no ovf flag rx", ovfFlag, 0);
    wr(3'd0, 8'h14); step(4);
    chk("R7 tx baud pulse", baudCnt, 2);
    chk("R7 no ovf flag tx", ovfFlag, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic testUpDown();
    int v;
    wr(3'd1, 8'h01); wr16(3'd4, 16'h0010); wr16(3'd2, 16'h0012);
    dirPin = 1'b0; wr(3'd0, 8'h04);
    step(2); rd16(3'd2, v); chk("R8 down count", v, 16'h0010);
    step(1); rd16(3'd2, v); chk("R8 underflow at capture", v, 16'hFFFF);
    chk("R8 ovf on underflow", ovfFlag, 1);
    chk("R9 ext toggles on underflow", extFlag, 1);
    wr(3'd0, 8'h44);
    chk("R9 ext masked from irq", irq, 0);
    dirPin = 1'b1; step(1);
    rd16(3'd2, v); chk("R8 up wrap reloads", v, 16'h0010);
    chk("R9 ext toggles back", extFlag, 0);
    chk("R8 ovf on up wrap", ovfFlag, 1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
  endtask

  task automatic testSoftExt();
    wr(3'd0, 8'h40);
    chk("R10 software ext irq", irq, 1);
    wr(3'd0, 8'h00);
    chk("R10 irq cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testUpReload();
    testCapture();
    testTrigDisabled();
    testTrigReload();
    testCaptureWrap();
    testCounterPin();
    testBaud();
    testUpDown();
    testSoftExt();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule